// File: doc/BRIEF.md
# Multi-Frame SPI Master Engine

This block is the serial side of an SPI master for clock polarity 0 and clock phase 0. It turns a stream of parallel frame requests into back-to-back serial frames and returns each received frame as a parallel word. A frame carries 4 to 32 bits, chosen per request. A request handshake with a last-frame flag groups frames into one transfer. The data-output enable stays asserted from the first frame to the last.

The serial clock runs at half the system clock. A separation selector decides what happens between two frames of one transfer. The select line can be released for one serial-clock period, or for a fixed number of idle periods. In concatenation mode the frames join into one continuous select-low run, so a leading command frame and the data frames behind it reach the slave as a single long frame. A free-running option keeps the serial clock toggling while select is released.

Top module: `spi_burst_master`

## Requirements
- R1: The frame length is taken from `frame_len` when a request is accepted and limited to the range 4..32: a value below 4 gives 4 bits and a value above 32 gives 32 bits. Exactly that many rising `sck` edges occur with `ss_n` low for the frame.
- R2: The low frame-length bits of `req_word` are sent most significant first. The bits seen on `miso` are placed in `rsp_word` with the first-received bit highest, right-justified and zero-extended.
- R3: `sck` has a period of two system clocks and idles low. `mosi` changes only while `sck` is low. `miso` is captured at the rising `sck` edge. Without free-running, `sck` is low whenever `ss_n` is high.
- R4: `ss_n` and `doe_n` are high after reset and while no transfer is in progress.
- R5: With `sep_mode` 2'b00 (2'b11 behaves the same), `ss_n` goes high for exactly one `sck` period (two clocks) between consecutive frames when the next request is waiting.
- R6: With `sep_mode` 2'b01, `ss_n` goes high for IDLE_PERIODS `sck` periods (6 clocks by default) between consecutive frames when the next request is waiting.
- R7: With `sep_mode` 2'b10, `ss_n` stays low across all frames of a transfer. When the next request is late, `ss_n` stays low and `sck` stays low until it arrives.
- R8: `doe_n` falls when the first frame starts, stays low through every gap, and rises in the same cycle that `rsp_valid` reports the frame marked last. `ss_n` is never low while `doe_n` is high.
- R9: `rsp_valid` is a single-cycle pulse, once per completed frame, in frame order.
- R10: With `free_run` set, `sck` toggles every system clock while `ss_n` is high.
- R11: A request is taken on a clock where `req_valid` and `req_ready` are both high. After the frame marked last, no further frame starts until a new request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sep_mode | input | 2 | Frame separation: 00 select pulse, 01 forced idle, 10 concatenate, 11 as 00 |
| free_run | input | 1 | Keep `sck` toggling while select is released |
| frame_len | input | 6 | Requested frame length in bits (limited to 4..32) |
| req_valid | input | 1 | Frame request valid |
| req_ready | output | 1 | Engine takes a request this cycle |
| req_word | input | 32 | Frame data, right-justified |
| req_last | input | 1 | This frame ends the transfer |
| rsp_valid | output | 1 | One-cycle pulse: a frame completed |
| rsp_word | output | 32 | Received frame, right-justified, zero-extended |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| doe_n | output | 1 | Active-low data-output enable |
| ss_n | output | 1 | Active-low slave select |

## Verification
A wrong bit count shows at the ports within one frame. The number of rising `sck` edges under select no longer matches the length, and `rsp_valid` fires early or late, with a shifted `rsp_word`. A separation state that is stuck or wrongly chosen shows within one gap as a select-high run of the wrong length. A lost last flag shows at the final done pulse as `doe_n` still asserted. A phase slip changes `mosi` while `sck` is high, which shows as corrupted data in the slave model on the very next bit.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  localparam int MIN_BITS = 4;

  typedef enum logic [1:0] {
    SEP_PULSE  = 2'b00,
    SEP_IDLE   = 2'b01,
    SEP_CONCAT = 2'b10,
    SEP_ALIAS  = 2'b11
  } sep_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_BIT  = 2'b01,
    ST_GAP  = 2'b10,
    ST_WAIT = 2'b11
  } eng_state_e;

endpackage

// File: rtl/spi_phase_gen.sv
module spi_phase_gen (
  input  logic clk,
  input  logic rst_n,
  output logic ph,
  output logic period_end
);

  // ph = 0: low half of an sck period, ph = 1: high half
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= 1'b0;
    else        ph <= ~ph;
  end

  assign period_end = ph;

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] load_word,
  input  logic [LEN_W-1:0]    load_len,
  input  logic                sample,
  input  logic                shift,
  input  logic                miso,
  output logic                mosi_bit,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                last_bit
);

  logic [MAX_BITS-1:0] tx_sh;
  logic [MAX_BITS-1:0] rx_sh;
  logic [LEN_W-1:0]    bits_left;

  // place the low len bits at the top of the shift register
  function automatic logic [MAX_BITS-1:0] left_align(input logic [MAX_BITS-1:0] word,
                                                     input logic [LEN_W-1:0] len);
    return word << (MAX_BITS - int'(len));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh     <= '0;
      rx_sh     <= '0;
      bits_left <= '0;
    end else if (load) begin
      tx_sh     <= left_align(load_word, load_len);
      rx_sh     <= '0;
      bits_left <= load_len - LEN_W'(1);
    end else begin
      if (sample) rx_sh <= {rx_sh[MAX_BITS-2:0], miso};
      if (shift) begin
        tx_sh     <= {tx_sh[MAX_BITS-2:0], 1'b0};
        bits_left <= bits_left - LEN_W'(1);
      end
    end
  end

  assign mosi_bit = tx_sh[MAX_BITS-1];
  assign rx_word  = rx_sh;
  assign last_bit = (bits_left == '0);

  // R1
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> (bits_left != '0));

endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_pkg::*;
#(
  parameter int MAX_BITS     = 32,
  parameter int LEN_W        = 6,
  parameter int IDLE_PERIODS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ph,
  input  logic [1:0]          sep_mode,
  input  logic                free_run,
  input  logic [LEN_W-1:0]    frame_len,
  input  logic                req_valid,
  input  logic                req_last,
  input  logic                last_bit,
  input  logic                mosi_bit,
  input  logic [MAX_BITS-1:0] rx_word,
  output logic                req_ready,
  output logic                load,
  output logic [LEN_W-1:0]    load_len,
  output logic                sample,
  output logic                shift,
  output logic                sck,
  output logic                mosi,
  output logic                ss_n,
  output logic                doe_n,
  output logic                rsp_valid,
  output logic [MAX_BITS-1:0] rsp_word
);

  localparam int GAP_W = (IDLE_PERIODS > 1) ? $clog2(IDLE_PERIODS) : 1;

  eng_state_e       st;
  logic [GAP_W-1:0] gap_cnt;
  logic             last_q;

  // named internal events
  logic in_bit, in_wait, concat, forced, frame_end, gap_over;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] raw);
    if (raw < LEN_W'(MIN_BITS)) return LEN_W'(MIN_BITS);
    if (raw > LEN_W'(MAX_BITS)) return LEN_W'(MAX_BITS);
    return raw;
  endfunction

  always_comb begin
    in_bit    = (st == ST_BIT);
    in_wait   = (st == ST_WAIT);
    concat    = (sep_mode == SEP_CONCAT);
    forced    = (sep_mode == SEP_IDLE);
    frame_end = in_bit && ph && last_bit;
    gap_over  = (st == ST_GAP) && (gap_cnt == '0);
    req_ready = ph && ((st == ST_IDLE) || in_wait || gap_over ||
                       (frame_end && !last_q && concat));
    load      = req_valid && req_ready;
    load_len  = clamp_len(frame_len);
    sample    = in_bit && !ph;
    shift     = in_bit && ph && !last_bit;
    sck       = ph && (in_bit || (free_run && !in_wait));
    ss_n      = !(in_bit || in_wait);
    doe_n     = (st == ST_IDLE);
    mosi      = (in_bit || in_wait) ? mosi_bit : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      gap_cnt   <= '0;
      last_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_word  <= '0;
    end else begin
      rsp_valid <= frame_end;
      if (frame_end) rsp_word <= rx_word;
      if (load) last_q <= req_last;
      unique case (st)
        ST_IDLE: if (load) st <= ST_BIT;
        ST_BIT: begin
          if (frame_end) begin
            if (last_q)      st <= ST_IDLE;
            else if (concat) st <= load ? ST_BIT : ST_WAIT;
            else begin
              st      <= ST_GAP;
              gap_cnt <= forced ? GAP_W'(IDLE_PERIODS - 1) : '0;
            end
          end
        end
        ST_GAP: begin
          if (ph) begin
            if (gap_cnt != '0) gap_cnt <= gap_cnt - GAP_W'(1);
            else if (load)     st <= ST_BIT;
          end
        end
        ST_WAIT: if (load) st <= ST_BIT;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_run && ss_n) |-> !sck);

  // R8
  ss_doe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n |-> !doe_n);

  // R8
  doe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doe_n) |-> rsp_valid);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10
  free_run_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_run && $past(free_run) && $past(rst_n) && ss_n && $past(ss_n))
      |-> (sck != $past(sck)));

endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int  MAX_BITS     = 32,
  parameter int  IDLE_PERIODS = 3,
  localparam int LEN_W        = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          sep_mode,
  input  logic                free_run,
  input  logic [LEN_W-1:0]    frame_len,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [MAX_BITS-1:0] req_word,
  input  logic                req_last,
  output logic                rsp_valid,
  output logic [MAX_BITS-1:0] rsp_word,
  output logic                sck,
  output logic                mosi,
  input  logic                miso,
  output logic                doe_n,
  output logic                ss_n
);

  logic                ph, period_end;
  logic                load, sample, shift, mosi_bit, last_bit;
  logic [LEN_W-1:0]    load_len;
  logic [MAX_BITS-1:0] rx_word;

  spi_phase_gen u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .ph         (ph),
    .period_end (period_end)
  );

  spi_frame_shifter #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_word (req_word),
    .load_len  (load_len),
    .sample    (sample),
    .shift     (shift),
    .miso      (miso),
    .mosi_bit  (mosi_bit),
    .rx_word   (rx_word),
    .last_bit  (last_bit)
  );

  spi_burst_ctrl #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .IDLE_PERIODS(IDLE_PERIODS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph        (period_end),
    .sep_mode  (sep_mode),
    .free_run  (free_run),
    .frame_len (frame_len),
    .req_valid (req_valid),
    .req_last  (req_last),
    .last_bit  (last_bit),
    .mosi_bit  (mosi_bit),
    .rx_word   (rx_word),
    .req_ready (req_ready),
    .load      (load),
    .load_len  (load_len),
    .sample    (sample),
    .shift     (shift),
    .sck       (sck),
    .mosi      (mosi),
    .ss_n      (ss_n),
    .doe_n     (doe_n),
    .rsp_valid (rsp_valid),
    .rsp_word  (rsp_word)
  );

  // R3
  mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  // R4
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doe_n |-> ss_n);

endmodule

// File: tb/spi_burst_master_bench.sv
module spi_burst_master_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sep_mode = 2'b00;
  logic        free_run = 1'b0;
  logic [5:0]  frame_len = 6'd8;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_word = '0;
  logic        req_last = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_word;
  logic        sck, mosi, doe_n, ss_n;
  logic        miso = 1'b0;

  always #2 clk = ~clk;

  spi_burst_master u_spi_burst_master (
    .clk(clk), .rst_n(rst_n), .sep_mode(sep_mode), .free_run(free_run),
    .frame_len(frame_len), .req_valid(req_valid), .req_ready(req_ready),
    .req_word(req_word), .req_last(req_last), .rsp_valid(rsp_valid),
    .rsp_word(rsp_word), .sck(sck), .mosi(mosi), .miso(miso),
    .doe_n(doe_n), .ss_n(ss_n)
  );

  // scoreboard storage: driver writes at sb_wr, monitor reads at sb_rd
  logic [31:0] exp_rx [0:63];
  logic [31:0] exp_tx [0:63];
  int          exp_len [0:63];
  logic        exp_last [0:63];
  int          sb_wr = 0;
  int          sb_rd = 0;

  // slave model storage
  logic        sl_mem [0:2047];
  int          sl_wr = 0;
  int          sl_rd = 0;
  logic        cap_mem [0:2047];
  int          cap_n = 0;
  logic        taken = 1'b0;

  int checks = 0, fails = 0;
  int mon_checks = 0, mon_fails = 0;
  int gaps = 0, gap_bad = 0, doe_bad = 0, sck_bad = 0, dbl = 0, rises = 0;
  int fr_bad = 0, idle_samp = 0, hi_run = 0, cons_n = 0;
  int exp_gap = 2;
  logic prev_rv = 1'b0, prev_sck = 1'b0;
  bit finished = 0;

  function automatic int eff_len(input int raw);
    if (raw < 4) return 4;
    if (raw > 32) return 32;
    return raw;
  endfunction

  function automatic logic [31:0] len_mask(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // slave: capture mosi on rising sck, advance miso on falling sck
  always @(sck) begin
    if (sck && !ss_n) begin
      cap_mem[cap_n] = mosi;
      cap_n++;
      taken = 1'b1;
    end else if (!sck && taken) begin
      sl_rd++;
      taken = 1'b0;
    end
  end

  always @(negedge clk) miso = (sl_rd < sl_wr) ? sl_mem[sl_rd] : 1'b0;

  // monitor: pops scoreboard on each done pulse, tracks line behaviour
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        logic [31:0] txw;
        int          len;
        len = exp_len[sb_rd];
        txw = '0;
        for (int i = 0; i < len; i++) txw = {txw[30:0], cap_mem[cons_n + i]};
        mon_checks += 4;
        if (sb_rd >= sb_wr) begin
          mon_fails++;
          $display("FAIL R9 actual=%0d expected=%0d (unexpected done)", sb_rd, sb_wr);
        end
        if (rsp_word !== exp_rx[sb_rd]) begin
          mon_fails++;
          $display("FAIL R2 rx actual=%h expected=%h", rsp_word, exp_rx[sb_rd]);
        end
        if (txw !== exp_tx[sb_rd]) begin
          mon_fails++;
          $display("FAIL R2 tx actual=%h expected=%h", txw, exp_tx[sb_rd]);
        end
        if ((cap_n - cons_n != len) || (doe_n !== exp_last[sb_rd])) begin
          mon_fails++;
          $display("FAIL R1/R8 bits actual=%0d expected=%0d doe_n=%b", cap_n - cons_n, len, doe_n);
        end
        cons_n = cap_n;
        sb_rd++;
      end
      if (rsp_valid && prev_rv) dbl++;
      prev_rv = rsp_valid;
      if (!doe_n && ss_n) hi_run++;
      else begin
        if (!doe_n && !ss_n && hi_run > 0) begin
          gaps++;
          if (hi_run != exp_gap) gap_bad++;
        end
        hi_run = 0;
      end
      if (!ss_n && doe_n) doe_bad++;
      if (!free_run && ss_n && sck) sck_bad++;
      if (!ss_n && sck && !prev_sck) rises++;
      if (free_run && ss_n && doe_n) begin
        idle_samp++;
        if (sck == prev_sck) fr_bad++;
      end
      prev_sck = sck;
    end
  end

  task automatic send_frame(input logic [31:0] data, input logic [31:0] sword,
                            input bit last, input int raw_len, input int pre_delay);
    int len;
    len = eff_len(raw_len);
    exp_rx[sb_wr]   = sword & len_mask(len);
    exp_tx[sb_wr]   = data & len_mask(len);
    exp_len[sb_wr]  = len;
    exp_last[sb_wr] = last;
    sb_wr++;
    for (int i = len - 1; i >= 0; i--) begin
      sl_mem[sl_wr] = sword[i];
      sl_wr++;
    end
    req_valid = 1'b0;
    repeat (pre_delay) @(negedge clk);
    req_valid = 1'b1;
    req_word  = data;
    req_last  = last;
    frame_len = 6'(raw_len);
    forever begin
      bit hs;
      hs = req_ready;
      @(posedge clk);
      if (hs) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_drain();
    while (sb_rd < sb_wr) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // run n frames and check the line behaviour of the whole transfer
  task automatic run_xfer(input string tag, input logic [1:0] mode, input bit fr,
                          input int n, input int raw_len, input int late_idx,
                          input int want_gap, input int want_gaps);
    int g0, gb0, d0, s0, db0, r0, fb0, is0, bits;
    @(negedge clk);
    sep_mode = mode;
    free_run = fr;
    exp_gap  = want_gap;
    repeat (4) @(negedge clk);
    g0 = gaps; gb0 = gap_bad; d0 = doe_bad; s0 = sck_bad; db0 = dbl;
    r0 = rises; fb0 = fr_bad; is0 = idle_samp;
    bits = 0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] d, s;
      d = 32'h9E37_79B9 * (i + 3) ^ {raw_len[7:0], 24'h5A_C3_96};
      s = 32'hC2B2_AE35 * (i + 7) ^ 32'h0F1E_2D3C;
      send_frame(d, s, i == n - 1, raw_len, (i == late_idx) ? 50 : 0);
      bits += eff_len(raw_len);
    end
    wait_drain();
    chk(gaps - g0 == want_gaps, {tag, " gap count"}, gaps - g0, want_gaps);
    chk(gap_bad == gb0, {tag, " gap length"}, gap_bad - gb0, 0);
    chk(rises - r0 == bits, "R1 sck edges under select", rises - r0, bits);
    chk(doe_bad == d0, "R8 select without enable", doe_bad - d0, 0);
    chk(sck_bad == s0, "R3 sck high while released", sck_bad - s0, 0);
    chk(dbl == db0, "R9 done width", dbl - db0, 0);
    if (fr) begin
      chk(fr_bad == fb0, "R10 free-run toggle", fr_bad - fb0, 0);
      chk(idle_samp > is0, "R10 free-run samples", idle_samp - is0, 1);
    end
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(doe_n && ss_n, "R11 no start after last", {doe_n, ss_n}, 3);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R4 reset state
    chk(ss_n === 1'b1, "R4 ss_n reset", ss_n, 1);
    chk(doe_n === 1'b1, "R4 doe_n reset", doe_n, 1);
    chk(sck === 1'b0, "R3 sck reset", sck, 0);
    chk(rsp_valid === 1'b0, "R9 done reset", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ss_n && doe_n, "R4 lines idle", {ss_n, doe_n}, 3);

    run_xfer("R5 pulse", 2'b00, 1'b0, 3, 8, -1, 2, 2);
    run_xfer("R6 forced idle", 2'b01, 1'b0, 3, 12, -1, 6, 2);
    run_xfer("R7 concat", 2'b10, 1'b0, 3, 16, 2, 0, 0);
    run_xfer("R7 concat long", 2'b10, 1'b0, 2, 32, -1, 0, 0);
    run_xfer("R1 short clamp", 2'b00, 1'b0, 2, 2, -1, 2, 1);
    run_xfer("R1 long clamp", 2'b00, 1'b0, 2, 40, -1, 2, 1);
    run_xfer("R1 odd length", 2'b01, 1'b0, 1, 5, -1, 6, 0);
    run_xfer("R10 free pulse", 2'b00, 1'b1, 2, 9, -1, 2, 1);
    run_xfer("R5 alias mode", 2'b11, 1'b0, 2, 24, -1, 2, 1);

    chk(sb_rd == sb_wr, "R11 every request answered", sb_rd, sb_wr);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             checks + mon_checks, fails + mon_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog actual=%0d expected=%0d", sb_rd, sb_wr);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***",
               checks + mon_checks + 1, fails + mon_fails + 1);
      $finish;
    end
  end

endmodule